// File: doc/BRIEF.md
# Receive Holding Queue with Error Reporting Modes

This block sits between a serial receiver's shift register and the CPU. When the receiver finishes a character, it pushes the data byte into a three-slot queue together with three per-character status bits: parity error, framing error and break. With the shift register, this gives four levels of buffering ahead of the CPU. A CPU read strobe pops the oldest entry. While a read is pending, the data at the output is the entry at the head of the queue.

The block reports data-ready, queue-full and overrun. A mode input selects how the three error flags are reported. In per-character mode they belong to the character now at the head of the queue. In block mode they are a sticky OR over every character that has reached the head since the last error-clear command, so software can check a whole message once at its end. Overrun is tracked separately from the per-entry flags. An interrupt output follows either data-ready or queue-full, as chosen by a select input.

Top module: `rx_hold_fifo`

## Requirements
- R1: During and after a synchronous reset, the queue is empty and rdy, full, ovr, all three reported flags and irq are 0.
- R2: rdy is 1 whenever at least one character is stored. Characters leave in arrival order, and a pushed character is visible one clock after the push.
- R3: full is 1 exactly when all three slots are occupied.
- R4: A read strobe while rdy is 1 removes the head entry and its status bits. A read strobe while the queue is empty has no effect.
- R5: A push while the queue is full and no read occurs is discarded, and the stored contents are unchanged.
- R6: ovr is set by a discarded push and stays set until an err_clear command. If err_clear and a discarded push occur in the same cycle, ovr is set.
- R7: A push and a read in the same cycle are both carried out, with no overrun, including when the queue is full.
- R8: When block_mode is 0, st_pe, st_fe and st_brk equal the flags of the head entry, and are 0 when the queue is empty.
- R9: When block_mode is 1, the reported flags are the OR of the flags of every character that has reached the head since the last err_clear. err_clear empties this accumulation, and a character reaching the head in the same cycle is still counted.
- R10: irq equals full when irq_sel_full is 1, and equals rdy when irq_sel_full is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Receiver has completed a character |
| push_data | input | 8 | Received data byte |
| push_pe | input | 1 | Parity error of the pushed character |
| push_fe | input | 1 | Framing error of the pushed character |
| push_brk | input | 1 | Break indication of the pushed character |
| rd_strobe | input | 1 | CPU read: pop the head entry |
| block_mode | input | 1 | 1 = accumulated flag reporting, 0 = per-character |
| err_clear | input | 1 | Clears the accumulated flags and overrun |
| irq_sel_full | input | 1 | 1 = interrupt on full, 0 = on data-ready |
| rd_data | output | 8 | Data of the head entry |
| rdy | output | 1 | At least one character stored |
| full | output | 1 | All slots occupied |
| ovr | output | 1 | Sticky overrun |
| st_pe | output | 1 | Reported parity error |
| st_fe | output | 1 | Reported framing error |
| st_brk | output | 1 | Reported break |
| irq | output | 1 | Interrupt request |

## Verification
Queue contents, rdy, full, ovr and the block-mode accumulation change on the first rising edge after the push, read or err_clear that causes them. The choice between per-character and accumulated flags, and the irq select, act in the same cycle because they only steer existing state. The bench drives every input just after a falling edge and samples at the next falling edge, so registered results are compared exactly one edge after their cause, and mode-driven results after their inputs have settled. A reference queue kept in the bench predicts each sample.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Status bits carried with every stored character
  typedef struct packed {
    logic pe;
    logic fe;
    logic brk;
  } rxq_flags_t;

  localparam int FLAG_W = $bits(rxq_flags_t);

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  rxq_flags_t        push_flags,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] head_data,
  output rxq_flags_t        head_flags,
  output logic              rdy_q,
  output logic              full_q,
  output logic              drop,
  output logic              arrive_valid,
  output rxq_flags_t        arrive_flags
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = DATA_W + FLAG_W;
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr, rd_ptr_inc, wr_ptr_inc;
  logic [CNT_W-1:0] count, cnt_nxt;
  logic             do_pop, do_push;
  logic [ENT_W-1:0] push_word, head_word, next_word;

  assign push_word = {push_flags, push_data};
  assign head_word = mem[rd_ptr];
  assign next_word = mem[rd_ptr_inc];

  always_comb begin
    rd_ptr_inc = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
    wr_ptr_inc = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
  end

  // A slot freed by a same-cycle read can take the incoming character
  always_comb begin
    do_pop  = rd_strobe && (count != '0);
    do_push = push_valid && ((count != CNT_FULL) || do_pop);
    drop    = push_valid && !do_push;
  end

  always_comb begin
    unique case ({do_push, do_pop})
      2'b10:   cnt_nxt = count + 1'b1;
      2'b01:   cnt_nxt = count - 1'b1;
      default: cnt_nxt = count;
    endcase
  end

  // Which character, if any, becomes the head on this edge
  always_comb begin
    arrive_valid = 1'b0;
    arrive_flags = '0;
    if (do_pop && (count >= CNT_W'(2))) begin
      arrive_valid = 1'b1;
      arrive_flags = rxq_flags_t'(next_word[ENT_W-1:DATA_W]);
    end else if (do_push && ((count == '0) || ((count == CNT_W'(1)) && do_pop))) begin
      arrive_valid = 1'b1;
      arrive_flags = push_flags;
    end
  end

  // Storage array without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      if (do_pop)  rd_ptr <= rd_ptr_inc;
      if (do_push) wr_ptr <= wr_ptr_inc;
      count  <= cnt_nxt;
      rdy_q  <= (cnt_nxt != '0);
      full_q <= (cnt_nxt == CNT_FULL);
    end
  end

  assign head_data  = head_word[DATA_W-1:0];
  assign head_flags = rxq_flags_t'(head_word[ENT_W-1:DATA_W]);

endmodule

// File: rtl/rxq_sticky.sv
module rxq_sticky
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       err_clear,
  input  logic       drop,
  input  logic       arrive_valid,
  input  rxq_flags_t arrive_flags,
  output rxq_flags_t acc_flags,
  output logic       ovr_q
);

  rxq_flags_t acc_base, acc_add;

  always_comb begin
    acc_base = err_clear ? rxq_flags_t'('0) : acc_flags;
    acc_add  = arrive_valid ? arrive_flags : rxq_flags_t'('0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_flags <= '0;
      ovr_q     <= 1'b0;
    end else begin
      acc_flags <= acc_base | acc_add;
      ovr_q     <= (ovr_q && !err_clear) || drop;
    end
  end

endmodule

// File: rtl/rxq_report.sv
module rxq_report
  import rxq_pkg::*;
(
  input  logic       block_mode,
  input  logic       irq_sel_full,
  input  logic       rdy_q,
  input  logic       full_q,
  input  rxq_flags_t head_flags,
  input  rxq_flags_t acc_flags,
  output rxq_flags_t shown_flags,
  output logic       irq
);

  always_comb begin
    if (block_mode)  shown_flags = acc_flags;
    else if (rdy_q)  shown_flags = head_flags;
    else             shown_flags = '0;
    irq = irq_sel_full ? full_q : rdy_q;
  end

endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_pe,
  input  logic              push_fe,
  input  logic              push_brk,
  input  logic              rd_strobe,
  input  logic              block_mode,
  input  logic              err_clear,
  input  logic              irq_sel_full,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy,
  output logic              full,
  output logic              ovr,
  output logic              st_pe,
  output logic              st_fe,
  output logic              st_brk,
  output logic              irq
);

  rxq_flags_t push_flags, head_flags, arrive_flags, acc_flags, shown_flags;
  logic       drop, arrive_valid;

  assign push_flags = '{pe: push_pe, fe: push_fe, brk: push_brk};

  rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk          (clk),
    .rst          (rst),
    .push_valid   (push_valid),
    .push_data    (push_data),
    .push_flags   (push_flags),
    .rd_strobe    (rd_strobe),
    .head_data    (rd_data),
    .head_flags   (head_flags),
    .rdy_q        (rdy),
    .full_q       (full),
    .drop         (drop),
    .arrive_valid (arrive_valid),
    .arrive_flags (arrive_flags)
  );

  rxq_sticky u_sticky (
    .clk          (clk),
    .rst          (rst),
    .err_clear    (err_clear),
    .drop         (drop),
    .arrive_valid (arrive_valid),
    .arrive_flags (arrive_flags),
    .acc_flags    (acc_flags),
    .ovr_q        (ovr)
  );

  rxq_report u_report (
    .block_mode   (block_mode),
    .irq_sel_full (irq_sel_full),
    .rdy_q        (rdy),
    .full_q       (full),
    .head_flags   (head_flags),
    .acc_flags    (acc_flags),
    .shown_flags  (shown_flags),
    .irq          (irq)
  );

  assign st_pe  = shown_flags.pe;
  assign st_fe  = shown_flags.fe;
  assign st_brk = shown_flags.brk;

endmodule

// File: rtl/rx_hold_fifo_chk.sv
module rx_hold_fifo_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              push_valid,
  input logic [DATA_W-1:0] push_data,
  input logic              push_pe,
  input logic              push_fe,
  input logic              push_brk,
  input logic              rd_strobe,
  input logic              block_mode,
  input logic              err_clear,
  input logic              irq_sel_full,
  input logic [DATA_W-1:0] rd_data,
  input logic              rdy,
  input logic              full,
  input logic              ovr,
  input logic              st_pe,
  input logic              st_fe,
  input logic              st_brk,
  input logic              irq
);

  p_reset_clean_r1: assert property (@(posedge clk)
    rst |=> (!rdy && !full && !ovr));

  p_full_implies_rdy_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> rdy);

  p_empty_read_noop_r4: assert property (@(posedge clk) disable iff (rst)
    (!rdy && rd_strobe && !push_valid) |=> !rdy);

  p_drop_sets_ovr_r5: assert property (@(posedge clk) disable iff (rst)
    (push_valid && full && !rd_strobe) |=> (ovr && full));

  p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ovr && !err_clear) |=> ovr);

  p_pushpop_full_no_ovr_r7: assert property (@(posedge clk) disable iff (rst)
    (push_valid && rd_strobe && full && !ovr && !err_clear) |=> (!ovr && full));

  p_empty_char_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (!block_mode && !rdy) |-> (!st_pe && !st_fe && !st_brk));

  p_block_pe_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (block_mode && st_pe && !err_clear ##1 block_mode) |-> st_pe);

  p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_sel_full ? !full : !rdy) |-> !irq);

endmodule

bind rx_hold_fifo rx_hold_fifo_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_rx_hold_fifo.sv
module test_rx_hold_fifo;

  localparam int CLK_P = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic push_pe = 1'b0, push_fe = 1'b0, push_brk = 1'b0;
  logic rd_strobe = 1'b0, block_mode = 1'b0, err_clear = 1'b0, irq_sel_full = 1'b0;
  logic [DW-1:0] rd_data;
  logic rdy, full, ovr, st_pe, st_fe, st_brk, irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // Scoreboard: {pe, fe, brk, data}
  logic [DW+2:0] sb[$];
  logic [2:0]    m_acc;
  logic          m_ovr;

  always #(CLK_P/2) clk = ~clk;

  rx_hold_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_rx_hold_fifo (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
    .push_pe(push_pe), .push_fe(push_fe), .push_brk(push_brk),
    .rd_strobe(rd_strobe), .block_mode(block_mode), .err_clear(err_clear),
    .irq_sel_full(irq_sel_full), .rd_data(rd_data), .rdy(rdy), .full(full),
    .ovr(ovr), .st_pe(st_pe), .st_fe(st_fe), .st_brk(st_brk), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // Monitor: compare every output with the scoreboard prediction
  task automatic check_all();
    logic [2:0] exp_fl;
    chk("R2 rdy", 32'(rdy), 32'(sb.size() != 0));
    chk("R3 full", 32'(full), 32'(sb.size() == DEPTH));
    if (sb.size() != 0) chk("R2 head data", 32'(rd_data), 32'(sb[0][DW-1:0]));
    chk("R6 ovr", 32'(ovr), 32'(m_ovr));
    if (block_mode) exp_fl = m_acc;
    else if (sb.size() != 0) exp_fl = sb[0][DW+2:DW];
    else exp_fl = 3'b000;
    chk(block_mode ? "R9 block flags" : "R8 char flags",
        32'({st_pe, st_fe, st_brk}), 32'(exp_fl));
    chk("R10 irq", 32'(irq), 32'(irq_sel_full ? (sb.size() == DEPTH) : (sb.size() != 0)));
  endtask

  // Driver: apply one cycle of stimulus at a falling edge, update the prediction,
  // then sample one edge later at the next falling edge
  task automatic step(input bit p, input logic [DW-1:0] d, input logic [2:0] fl,
                      input bit rd, input bit clr);
    int  prev;
    bit  pop, pushok, drop, arrive;
    push_valid = p; push_data = d; {push_pe, push_fe, push_brk} = fl;
    rd_strobe = rd; err_clear = clr;
    prev   = sb.size();
    pop    = rd && (prev != 0);
    pushok = p && ((prev < DEPTH) || pop);
    drop   = p && !pushok;
    if (pop)    void'(sb.pop_front());
    if (pushok) sb.push_back({fl, d});
    arrive = (pop && sb.size() != 0) || (prev == 0 && pushok);
    m_acc  = (clr ? 3'b000 : m_acc) | (arrive ? sb[0][DW+2:DW] : 3'b000);
    m_ovr  = (m_ovr && !clr) || drop;
    @(negedge clk);
    check_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    m_acc = '0; m_ovr = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held and just after release
    chk("R1 rdy in reset", 32'(rdy), 0);
    chk("R1 ovr in reset", 32'(ovr), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 full", 32'(full), 0);
    chk("R1 flags", 32'({st_pe, st_fe, st_brk}), 0);
    chk("R1 irq", 32'(irq), 0);
    check_all();

    // R4: read of an empty queue changes nothing
    step(0, 8'h00, 3'b000, 1, 0);

    // R2/R3/R8: fill with distinct flag patterns in per-character mode
    step(1, 8'hA5, 3'b100, 0, 0);
    step(1, 8'h3C, 3'b000, 0, 0);
    irq_sel_full = 1'b1;
    step(1, 8'h7E, 3'b011, 0, 0);
    chk("R3 full after third push", 32'(full), 1);
    chk("R10 irq on full", 32'(irq), 1);

    // R5/R6: fourth push while full is dropped; overrun sticks
    step(1, 8'hEE, 3'b111, 0, 0);
    chk("R5 head unchanged", 32'(rd_data), 32'h0000_00A5);
    chk("R6 ovr set", 32'(ovr), 1);
    step(0, 8'h00, 3'b000, 0, 0);
    chk("R6 ovr held", 32'(ovr), 1);

    // R7: push and read together while full
    step(1, 8'h11, 3'b010, 1, 0);
    chk("R7 no new overrun, still full", 32'(full), 1);
    chk("R7 head advanced", 32'(rd_data), 32'h0000_003C);

    // R6: clear overrun
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R6 ovr cleared", 32'(ovr), 0);

    // R9: block mode accumulation from a fresh clear
    block_mode = 1'b1;
    irq_sel_full = 1'b0;
    step(0, 8'h00, 3'b000, 1, 0);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R9 accumulated fe|brk|fe", 32'({st_pe, st_fe, st_brk}), 32'b011);
    step(0, 8'h00, 3'b000, 1, 0);
    chk("R4 drained", 32'(rdy), 0);
    chk("R9 flags hold after drain", 32'({st_pe, st_fe, st_brk}), 32'b011);
    // R9: clear in the same cycle a character reaches the head
    step(1, 8'h42, 3'b100, 0, 1);
    chk("R9 clear with arrival", 32'({st_pe, st_fe, st_brk}), 32'b100);
    // R7: push and read together with one entry
    step(1, 8'h43, 3'b001, 1, 0);
    chk("R7 replaced head", 32'(rd_data), 32'h0000_0043);
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R9 cleared", 32'({st_pe, st_fe, st_brk}), 0);
    block_mode = 1'b0;
    step(0, 8'h00, 3'b000, 0, 0);
    chk("R8 char mode head flags", 32'({st_pe, st_fe, st_brk}), 32'b001);

    // Pseudo-random traffic over all inputs
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      block_mode   = lfsr[3];
      irq_sel_full = lfsr[9];
      step(lfsr[0] | lfsr[5], lfsr[15:8], lfsr[6:4], lfsr[1] & lfsr[7],
           (lfsr[11:8] == 4'hF));
    end

    // R1: reset in mid-traffic empties everything
    step(1, 8'h55, 3'b111, 0, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    push_valid = 1'b0; rd_strobe = 1'b0; err_clear = 1'b0;
    sb.delete(); m_acc = '0; m_ovr = 1'b0;
    @(negedge clk);
    chk("R1 rdy after reset", 32'(rdy), 0);
    check_all();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule